// File: doc/BRIEF.md
# Receive Byte Queue with Error Tags and Idle Timeout

This block sits between a serial receiver and a host read port. Each byte that the receiver completes is stored together with three error-tag bits. The oldest stored byte is always presented to the host as a holding register, and the tags of that byte are presented beside it. A host read strobe retires the head entry, so the next byte and its own tags appear on the following cycle.

The interrupt output reports a fill condition and an idle condition. In queue mode, the fill condition asserts once the number of stored bytes reaches a selectable threshold. In single-byte mode, it asserts whenever one byte is held. The idle condition asserts when bytes are waiting and no byte has been written or read for an interval derived from the character width. A single enable gates both conditions.

Top module: `rx_tag_fifo`

## Requirements
- R1: The block stores up to 16 entries of 11 bits: a byte plus 3 tag bits. Entries leave in arrival order. `head_data` and `head_tags` show the oldest entry and read as zero when the block is empty. `data_ready` is high exactly when at least one entry is held.
- R2: A `rd_en` pulse while non-empty removes the head entry. From the next cycle, the outputs show the following entry's byte and tags. A `rd_en` pulse while empty has no effect.
- R3: A `wr_en` pulse when the block is at capacity discards the incoming byte and sets the sticky `overrun` flag. A `status_rd` pulse clears the flag. If a discard and a `status_rd` pulse fall in the same cycle, the flag ends up set.
- R4: With `fifo_en` low, the capacity is one entry, and the fill condition is true whenever that entry is held.
- R5: With `fifo_en` high, capacity is 16 entries. The fill condition is true when the stored count is at least the threshold selected by `trig_sel`: code 0 selects 1, code 1 selects 4, code 2 selects 8, and code 3 selects 14.
- R6: In queue mode, an idle counter advances on each `bit_tick` while the block is non-empty. The counter is cleared in any cycle with an accepted write, an accepted read, an empty block, or `fifo_en` low. When the counter completes 4*(5+`word_len`)+12 ticks, the timeout flag sets. An accepted read clears the flag.
- R7: `irq` = `irq_en` AND (fill condition OR timeout flag).
- R8: A cycle in which `fifo_en` differs from its value in the previous cycle empties the block and clears the timeout flag. A write or read in that cycle is ignored. Out of reset, `fifo_en` is taken to have been low.
- R9: While reset is active, the block is empty, and `head_data`, `head_tags`, `data_ready`, `overrun` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver delivers a byte |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags of the received byte |
| rd_en | input | 1 | Host reads the holding register |
| status_rd | input | 1 | Host reads status; clears overrun |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single-byte holding |
| irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Fill threshold code |
| word_len | input | 2 | Character data bits minus 5 |
| bit_tick | input | 1 | One pulse per serial bit time |
| head_data | output | 8 | Oldest stored byte |
| head_tags | output | 3 | Tags of the oldest stored byte |
| data_ready | output | 1 | At least one byte held |
| overrun | output | 1 | Sticky discard flag |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that `fifo_en` holds steady for long stretches and that `bit_tick` is a single-cycle pulse. They also assume that `trig_sel` and `word_len` change only between bursts of traffic. The directed phases hold these settings constant while filling, draining and idling the queue. A final random phase toggles `fifo_en` only rarely, so that mode-change flushes are hit without the block being flushed constantly. Strobes are driven one cycle at a time, and reads, writes and discards are allowed to coincide freely.

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DW    = 8,
  parameter int TW    = 3,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [TW-1:0] wr_tags,
  input  logic          rd_en,
  input  logic          status_rd,
  input  logic          fifo_en,
  input  logic          irq_en,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    word_len,
  input  logic          bit_tick,
  output logic [DW-1:0] head_data,
  output logic [TW-1:0] head_tags,
  output logic          data_ready,
  output logic          overrun,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + TW;
  localparam int CW = 7;

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          en_q, tout;
  logic [CW-1:0] tcnt;

  wire [AW:0] count = wp - rp;
  wire        empty = (count == '0);
  wire [AW:0] cap   = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
  wire        full  = (count >= cap);
  wire        flush = (fifo_en != en_q);
  wire        wr_ok = wr_en && !full && !flush;
  wire        rd_ok = rd_en && !empty && !flush;
  wire [CW-1:0] lim = CW'(32) + CW'({word_len, 2'b00});

  logic [AW:0] trig;
  always_comb begin
    case (trig_sel)
      2'd0:    trig = (AW+1)'(1);
      2'd1:    trig = (AW+1)'(4);
      2'd2:    trig = (AW+1)'(8);
      default: trig = (AW+1)'(14);
    endcase
  end

  wire level = fifo_en ? (count >= trig) : !empty;

  assign head_data  = empty ? '0 : mem[rp[AW-1:0]][DW-1:0];
  assign head_tags  = empty ? '0 : mem[rp[AW-1:0]][EW-1:DW];
  assign data_ready = !empty;
  assign irq        = irq_en && (level || tout);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp[AW-1:0]] <= {wr_tags, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      en_q    <= 1'b0;
      overrun <= 1'b0;
      tcnt    <= '0;
      tout    <= 1'b0;
    end else begin
      en_q <= fifo_en;
      if (status_rd) overrun <= 1'b0;
      if (wr_en && full && !flush) overrun <= 1'b1;
      if (flush) begin
        wp   <= '0;
        rp   <= '0;
        tcnt <= '0;
        tout <= 1'b0;
      end else begin
        if (wr_ok) wp <= wp + 1'b1;
        if (rd_ok) rp <= rp + 1'b1;
        if (wr_ok || rd_ok || empty || !fifo_en) tcnt <= '0;
        else if (bit_tick && !tout) begin
          if (tcnt == lim - 1'b1) begin
            tout <= 1'b1;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        if (rd_ok) tout <= 1'b0;
      end
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  assert_read_pops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !wr_en && !flush) |=> count == $past(count) - 1'b1);

  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush) |=> overrun);

  assert_single_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !en_q) |-> count <= (AW+1)'(1));

  assert_top_level_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && fifo_en && count >= (AW+1)'(14)) |-> irq);

  assert_tout_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tout |-> !empty);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: tb/tb_rx_tag_fifo.sv
module tb_rx_tag_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, status_rd = 0, fifo_en = 0, irq_en = 0, bit_tick = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_tags = 0;
  logic [1:0] trig_sel = 0, word_len = 0;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic data_ready, overrun, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_tag_fifo dut (.clk, .rst_n, .wr_en, .wr_data, .wr_tags, .rd_en, .status_rd,
    .fifo_en, .irq_en, .trig_sel, .word_len, .bit_tick, .head_data, .head_tags,
    .data_ready, .overrun, .irq);

  logic [10:0] q[$];
  int  tcnt;
  bit  tout, ovr, prev_en;
  int  vectors = 0, errors = 0;
  bit  done = 0;
  string phase = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); tcnt = 0; tout = 0; ovr = 0; prev_en = 0;
    end else begin
      int cap, lim;
      bit fl, wa, ra, emp;
      fl  = (fifo_en != prev_en);
      cap = fifo_en ? 16 : 1;
      emp = (q.size() == 0);
      if (status_rd) ovr = 0;
      if (wr_en && q.size() >= cap && !fl) ovr = 1;
      if (fl) begin
        q.delete(); tcnt = 0; tout = 0;
      end else begin
        wa  = wr_en && q.size() < cap;
        ra  = rd_en && !emp;
        lim = 4 * (5 + word_len) + 12;
        if (wa || ra || emp || !fifo_en) tcnt = 0;
        else if (bit_tick && !tout) begin
          if (tcnt == lim - 1) begin tout = 1; tcnt = 0; end
          else tcnt++;
        end
        if (ra) begin void'(q.pop_front()); tout = 0; end
        if (wa) q.push_back({wr_tags, wr_data});
      end
      prev_en = fifo_en;
    end
  end

  task automatic chk(string what, string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s/%s] actual=%0d expected=%0d at %0t", tag, phase, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int trig [4] = '{1, 4, 8, 14};
    bit lvl;
    lvl = fifo_en ? (q.size() >= trig[trig_sel]) : (q.size() > 0);
    chk("head_data",  "R1", head_data, q.size() ? int'(q[0][7:0])  : 0);
    chk("head_tags",  "R2", head_tags, q.size() ? int'(q[0][10:8]) : 0);
    chk("data_ready", "R1", data_ready, q.size() > 0);
    chk("overrun",    "R3", overrun, ovr);
    chk("irq",        "R7", irq, irq_en && (lvl || tout));
  endtask

  task automatic cyc(bit w, bit r, bit s, bit t);
    @(negedge clk);
    compare();
    wr_en = w; rd_en = r; status_rd = s; bit_tick = t;
    wr_data = 8'($urandom); wr_tags = 3'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("reset_data",  "R9", head_data, 0);
      chk("reset_ready", "R9", data_ready, 0);
      chk("reset_ovr",   "R9", overrun, 0);
      chk("reset_irq",   "R9", irq, 0);
    end
    rst_n = 1;
    fifo_en = 1; irq_en = 1;

    phase = "R5";
    for (int ts = 0; ts < 4; ts++) begin
      trig_sel = 2'(ts);
      for (int i = 0; i < 18; i++) cyc(1, 0, 0, 0);
      cyc(0, 0, 1, 0);
      for (int i = 0; i < 18; i++) cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 0);
    end

    phase = "R6";
    trig_sel = 3;
    for (int wl = 0; wl < 4; wl++) begin
      word_len = 2'(wl);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      for (int i = 0; i < 50; i++) cyc(0, 0, 0, 1);
      cyc(0, 1, 0, 0);
      for (int i = 0; i < 50; i++) cyc(0, 0, 0, i % 2);
      cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 1);
    end

    phase = "R4";
    fifo_en = 0;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 1);
    cyc(0, 1, 1, 0); cyc(0, 0, 0, 0); cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 0); cyc(0, 0, 0, 0);

    phase = "R8";
    fifo_en = 1; trig_sel = 1;
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
    fifo_en = 0;
    cyc(1, 1, 0, 0); cyc(0, 0, 0, 0);
    fifo_en = 1;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);

    phase = "R7";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 16) == 0, ($urandom % 2) == 0);
      if ($urandom % 97 == 0) irq_en = ~irq_en;
      if ($urandom % 211 == 0) trig_sel = 2'($urandom);
      if ($urandom % 173 == 0) word_len = 2'($urandom);
      if ($urandom % 499 == 0) fifo_en = ~fifo_en;
      if (i % 1000 == 500) repeat (80) cyc(0, 0, 0, 1);
    end
    cyc(0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule